// File: doc/BRIEF.md
# Banked Data Address Remapper

This block turns the short file operand of an instruction into a full 12-bit data-memory address. An access names an 8-bit operand and a one-bit select. With the select set, the operand is appended to a 4-bit bank register. With the select clear, the operand reaches the shared region. In that region the top part of the operand range always lands in the special-register page at the top of memory. When the extended mode input is high, the bottom 96 operands are moved onto a 96-byte window that starts at a 12-bit frame pointer. When extended mode is low, they land in bank 0.

The block holds the bank register and the frame pointer. Each has its own write port, and the pointer is written as a 4-bit high part and an 8-bit low part. An access can be flagged as an explicit indirect operand. In that case, the address supplied with the access is used unchanged and no remapping happens. The resolved address is combinational. It also drives a small synchronous data RAM, whose read data comes out one clock later.

Top module: `data_addr_remap`

## Requirements
- R1: When the indirect flag is 0 and the select bit is 1, the address is {bank register, operand}, in either mode.
- R2: When the indirect flag is 0, the select bit is 0, extended mode is 1 and the operand is below 60h, the address is frame pointer + operand. With the pointer at 120h, operands 00h–5Fh give 120h–17Fh.
- R3: When the indirect flag is 0, the select bit is 0 and the operand is 60h or above, the address is F00h + operand, in either mode.
- R4: When the indirect flag is 0, the select bit is 0, extended mode is 0 and the operand is below 60h, the address is the operand, in bank 0.
- R5: When the indirect flag is 1, the address equals the supplied indirect address, whatever the select bit, mode, operand or pointer value.
- R6: After reset, the bank register is 0, the frame pointer is 000h and the read data is 00h.
- R7: A register write takes effect at the next rising edge, and an access in the same cycle as the write resolves with the old value. The pointer's high part (4 bits) and low part (8 bits) are written independently.
- R8: The pointer-plus-operand sum wraps modulo 4096.
- R9: With the access valid and the RAM write enable high, the write data is stored at the resolved address modulo the RAM depth (1024 by default) at the next edge. With the access valid and the write enable low, the read data shows that location's contents after the next edge. Otherwise the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 4 | Bank register write value |
| fp_hi_we | input | 1 | Frame pointer high part write enable |
| fp_hi_wdata | input | 4 | Frame pointer bits 11:8 |
| fp_lo_we | input | 1 | Frame pointer low part write enable |
| fp_lo_wdata | input | 8 | Frame pointer bits 7:0 |
| ext_mode | input | 1 | Enables the pointer-relative window |
| acc_valid | input | 1 | An access to the RAM is requested |
| acc_operand | input | 8 | Instruction file operand |
| acc_banked | input | 1 | Select bit: 1 uses the bank register, 0 uses the shared region |
| acc_indirect | input | 1 | Access is an explicit indirect operand |
| acc_ind_addr | input | 12 | Address supplied for indirect accesses |
| ram_we | input | 1 | Write the RAM at the resolved address |
| ram_wdata | input | 8 | RAM write data |
| res_addr | output | 12 | Resolved address, same cycle |
| rd_data | output | 8 | RAM read data, one cycle after the read |

## Verification
The bench sweeps the operand across the 5Fh/60h boundary in both modes and with the select bit either way. A wrong threshold would send operand 5Fh to F5Fh, or operand 60h into the window. It moves the pointer near FFFh to check the wrap. A carry into a thirteenth bit, or a saturating sum, would give addresses past the top of memory. It writes registers in the same cycle as an access, which catches a design that forwards the new value. It also sends indirect accesses whose address matches the window, which catches a design that remaps indirect accesses.

// File: rtl/data_addr_remap_pkg.sv
package data_addr_remap_pkg;

   // Which rule produced a resolved address
   typedef enum logic [2:0] {
      SRC_INDIRECT = 3'd0,
      SRC_BANKED   = 3'd1,
      SRC_WINDOW   = 3'd2,
      SRC_LOWBANK  = 3'd3,
      SRC_SPECIAL  = 3'd4
   } addr_src_e;

   // Fixed sizes of the access region
   localparam int unsigned WINDOW_BYTES = 96;

endpackage

// File: rtl/remap_regs.sv
module remap_regs #(
   parameter int unsigned BANK_W = 4,
   parameter int unsigned OPND_W = 8,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wdata,
   input  logic              fp_hi_we,
   input  logic [ADDR_W-OPND_W-1:0] fp_hi_wdata,
   input  logic              fp_lo_we,
   input  logic [OPND_W-1:0] fp_lo_wdata,
   output logic [BANK_W-1:0] bank_q,
   output logic [ADDR_W-1:0] fp_q
);
   localparam int unsigned HI_W = ADDR_W - OPND_W;

   initial begin
      if (HI_W < 1) $error("remap_regs: ADDR_W must exceed OPND_W");
   end

   logic [HI_W-1:0]   fp_hi_q;
   logic [OPND_W-1:0] fp_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (bank_we) begin
         bank_q <= bank_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_hi_q <= '0;
      end else if (fp_hi_we) begin
         fp_hi_q <= fp_hi_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_lo_q <= '0;
      end else if (fp_lo_we) begin
         fp_lo_q <= fp_lo_wdata;
      end
   end

   assign fp_q = {fp_hi_q, fp_lo_q};
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
   import data_addr_remap_pkg::*;
#(
   parameter int unsigned BANK_W   = 4,
   parameter int unsigned OPND_W   = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned WIN_SIZE = WINDOW_BYTES
) (
   input  logic              ext_mode,
   input  logic [OPND_W-1:0] operand,
   input  logic              banked,
   input  logic              indirect,
   input  logic [ADDR_W-1:0] ind_addr,
   input  logic [BANK_W-1:0] bank_q,
   input  logic [ADDR_W-1:0] fp_q,
   output logic [ADDR_W-1:0] addr,
   output addr_src_e         src
);
   localparam int unsigned HI_W = ADDR_W - OPND_W;
   localparam logic [OPND_W:0] WIN_LIM = (OPND_W+1)'(WIN_SIZE);
   localparam logic [HI_W-1:0] TOP_PAGE = {HI_W{1'b1}};

   initial begin
      if (BANK_W + OPND_W != ADDR_W) $error("addr_resolver: BANK_W+OPND_W must equal ADDR_W");
      if (WIN_SIZE == 0 || WIN_SIZE > (1 << OPND_W)) $error("addr_resolver: bad WIN_SIZE");
   end

   logic              in_low;
   logic [ADDR_W-1:0] win_sum;

   assign in_low  = ({1'b0, operand} < WIN_LIM);
   // Sum truncated to ADDR_W: wraps modulo the address space
   assign win_sum = fp_q + {{HI_W{1'b0}}, operand};

   always_comb begin
      if (indirect) begin
         src = SRC_INDIRECT;
      end else if (banked) begin
         src = SRC_BANKED;
      end else if (!in_low) begin
         src = SRC_SPECIAL;
      end else if (ext_mode) begin
         src = SRC_WINDOW;
      end else begin
         src = SRC_LOWBANK;
      end
   end

   always_comb begin
      unique case (src)
         SRC_INDIRECT: addr = ind_addr;
         SRC_BANKED:   addr = {bank_q, operand};
         SRC_WINDOW:   addr = win_sum;
         SRC_SPECIAL:  addr = {TOP_PAGE, operand};
         default:      addr = {{HI_W{1'b0}}, operand};
      endcase
   end
endmodule

// File: rtl/remap_ram.sv
module remap_ram #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      if ((DEPTH & (DEPTH - 1)) != 0) $error("remap_ram: DEPTH must be a power of two");
      if (DEPTH > (1 << ADDR_W)) $error("remap_ram: DEPTH exceeds address space");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (IDX_W == ADDR_W) begin : g_full
         assign idx = addr;
      end else begin : g_alias
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:IDX_W];
         assign idx       = addr[IDX_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (valid && we) begin
         mem[idx] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (valid && !we) begin
         rdata <= mem[idx];
      end
   end
endmodule

// File: rtl/data_addr_remap.sv
module data_addr_remap
   import data_addr_remap_pkg::*;
#(
   parameter int unsigned BANK_W    = 4,
   parameter int unsigned OPND_W    = 8,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RAM_DEPTH = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [3:0]        bank_wdata,
   input  logic              fp_hi_we,
   input  logic [3:0]        fp_hi_wdata,
   input  logic              fp_lo_we,
   input  logic [7:0]        fp_lo_wdata,
   input  logic              ext_mode,
   input  logic              acc_valid,
   input  logic [7:0]        acc_operand,
   input  logic              acc_banked,
   input  logic              acc_indirect,
   input  logic [11:0]       acc_ind_addr,
   input  logic              ram_we,
   input  logic [7:0]        ram_wdata,
   output logic [11:0]       res_addr,
   output logic [7:0]        rd_data
);
   initial begin
      if (BANK_W != 4 || OPND_W != 8 || ADDR_W != 12 || DATA_W != 8)
         $error("data_addr_remap: port widths are fixed at 4/8/12/8");
   end

   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] fp_q;
   addr_src_e         src;

   remap_regs #(.BANK_W(BANK_W), .OPND_W(OPND_W), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bank_we     (bank_we),
      .bank_wdata  (bank_wdata),
      .fp_hi_we    (fp_hi_we),
      .fp_hi_wdata (fp_hi_wdata),
      .fp_lo_we    (fp_lo_we),
      .fp_lo_wdata (fp_lo_wdata),
      .bank_q      (bank_q),
      .fp_q        (fp_q)
   );

   addr_resolver #(.BANK_W(BANK_W), .OPND_W(OPND_W), .ADDR_W(ADDR_W)) u_res (
      .ext_mode (ext_mode),
      .operand  (acc_operand),
      .banked   (acc_banked),
      .indirect (acc_indirect),
      .ind_addr (acc_ind_addr),
      .bank_q   (bank_q),
      .fp_q     (fp_q),
      .addr     (res_addr),
      .src      (src)
   );

   remap_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (acc_valid),
      .we    (ram_we),
      .addr  (res_addr),
      .wdata (ram_wdata),
      .rdata (rd_data)
   );
endmodule

// File: rtl/data_addr_remap_chk.sv
module data_addr_remap_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bank_we,
   input logic [3:0]  bank_wdata,
   input logic        fp_lo_we,
   input logic [7:0]  fp_lo_wdata,
   input logic        ext_mode,
   input logic [7:0]  acc_operand,
   input logic        acc_banked,
   input logic        acc_indirect,
   input logic [11:0] acc_ind_addr,
   input logic [3:0]  bank_q,
   input logic [11:0] fp_q,
   input logic [11:0] res_addr
);
   // R5: indirect address passes through untouched
   a_r5_indirect_pass: assert property (@(posedge clk) disable iff (!rst_n)
      acc_indirect |-> res_addr == acc_ind_addr);

   // R1: banked access uses the bank register
   a_r1_banked: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_indirect && acc_banked) |-> res_addr == {bank_q, acc_operand});

   // R3: upper operands reach the top page in both modes
   a_r3_special_page: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_indirect && !acc_banked && acc_operand >= 8'h60) |-> res_addr[11:8] == 4'hF);

   // R4: lower operands stay in bank 0 outside extended mode
   a_r4_low_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_indirect && !acc_banked && !ext_mode && acc_operand < 8'h60)
      |-> res_addr == {4'h0, acc_operand});

   // R2: window address minus operand gives the pointer back (R8 wrap included)
   a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_indirect && !acc_banked && ext_mode && acc_operand < 8'h60)
      |-> 12'(res_addr - {4'h0, acc_operand}) == fp_q);

   // R7: register writes land at the next edge
   a_r7_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> bank_q == $past(bank_wdata));

   a_r7_fp_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
      fp_lo_we |=> fp_q[7:0] == $past(fp_lo_wdata));
endmodule

bind data_addr_remap data_addr_remap_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bank_we      (bank_we),
   .bank_wdata   (bank_wdata),
   .fp_lo_we     (fp_lo_we),
   .fp_lo_wdata  (fp_lo_wdata),
   .ext_mode     (ext_mode),
   .acc_operand  (acc_operand),
   .acc_banked   (acc_banked),
   .acc_indirect (acc_indirect),
   .acc_ind_addr (acc_ind_addr),
   .bank_q       (bank_q),
   .fp_q         (fp_q),
   .res_addr     (res_addr)
);

// File: tb/sim_data_addr_remap.sv
`timescale 1ns/1ps
module sim_data_addr_remap;
   localparam int DEPTH = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bank_we = 0, fp_hi_we = 0, fp_lo_we = 0;
   logic [3:0]  bank_wdata = 0, fp_hi_wdata = 0;
   logic [7:0]  fp_lo_wdata = 0;
   logic        ext_mode = 0, acc_valid = 0, acc_banked = 0, acc_indirect = 0, ram_we = 0;
   logic [7:0]  acc_operand = 0, ram_wdata = 0;
   logic [11:0] acc_ind_addr = 0;
   logic [11:0] res_addr;
   logic [7:0]  rd_data;

   data_addr_remap u0 (
      .clk(clk), .rst_n(rst_n),
      .bank_we(bank_we), .bank_wdata(bank_wdata),
      .fp_hi_we(fp_hi_we), .fp_hi_wdata(fp_hi_wdata),
      .fp_lo_we(fp_lo_we), .fp_lo_wdata(fp_lo_wdata),
      .ext_mode(ext_mode), .acc_valid(acc_valid), .acc_operand(acc_operand),
      .acc_banked(acc_banked), .acc_indirect(acc_indirect), .acc_ind_addr(acc_ind_addr),
      .ram_we(ram_we), .ram_wdata(ram_wdata),
      .res_addr(res_addr), .rd_data(rd_data)
   );

   always #2 clk = ~clk;

   int tests = 0, fails = 0;
   bit done = 0;

   // Behavioural reference state
   int bank_m = 0, fp_m = 0, rd_m = 0;
   int mem_m [DEPTH];

   function automatic int exp_addr(output string tag);
      int op = int'(acc_operand);
      if (acc_indirect) begin tag = "R5"; return int'(acc_ind_addr); end
      if (acc_banked)   begin tag = "R1"; return bank_m * 256 + op; end
      if (op >= 96)     begin tag = "R3"; return 3840 + op; end
      if (ext_mode)     begin tag = (fp_m + op > 4095) ? "R8" : "R2"; return (fp_m + op) % 4096; end
      tag = "R4";
      return op;
   endfunction

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check address, clock, update model, check read data
   task automatic cyc(bit bw, int bv, bit hw, int hv, bit lw, int lv, bit ext,
                      bit sel, bit ind, int op, int ia, bit v, bit we, int wd, string stag);
      string tag;
      int ea, idx;
      @(negedge clk);
      bank_we = bw; bank_wdata = 4'(bv);
      fp_hi_we = hw; fp_hi_wdata = 4'(hv);
      fp_lo_we = lw; fp_lo_wdata = 8'(lv);
      ext_mode = ext; acc_banked = sel; acc_indirect = ind;
      acc_operand = 8'(op); acc_ind_addr = 12'(ia);
      acc_valid = v; ram_we = we; ram_wdata = 8'(wd);
      #1;
      ea = exp_addr(tag);
      check((stag != "") ? stag : tag, int'(res_addr), ea);
      @(posedge clk);
      idx = ea % DEPTH;
      if (v && we) mem_m[idx] = wd;
      else if (v) rd_m = mem_m[idx];
      if (bw) bank_m = bv;
      if (hw) fp_m = (fp_m % 256) + hv * 256;
      if (lw) fp_m = (fp_m / 256) * 256 + lv;
      @(negedge clk);
      bank_we = 0; fp_hi_we = 0; fp_lo_we = 0; acc_valid = 0; ram_we = 0;
      if (rd_m >= 0) check("R9", int'(rd_data), rd_m);
   endtask

   task automatic acc(bit ext, bit sel, int op, bit v, bit we, int wd);
      cyc(0, 0, 0, 0, 0, 0, ext, sel, 0, op, 0, v, we, wd, "");
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      foreach (mem_m[i]) mem_m[i] = -1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R6 reset state
      @(negedge clk);
      check("R6", int'(rd_data), 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 8'h34, 0, 0, 0, 0, "R6");
      cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h10, 0, 0, 0, 0, "R6");
      // R7 same-cycle write sees old bank value, next cycle the new one
      cyc(1, 5, 0, 0, 0, 0, 0, 1, 0, 8'h22, 0, 0, 0, 0, "R7");
      acc(0, 1, 8'h22, 0, 0, 0);
      // R7 pointer halves written separately
      cyc(0, 0, 1, 1, 0, 0, 1, 0, 0, 8'h00, 0, 0, 0, 0, "R7");
      cyc(0, 0, 0, 0, 1, 8'h20, 1, 0, 0, 8'h00, 0, 0, 0, 0, "R7");
      // R2 window at 120h
      acc(1, 0, 8'h00, 1, 1, 8'hA1);
      acc(1, 0, 8'h5F, 1, 1, 8'hB2);
      acc(1, 0, 8'h30, 0, 0, 0);
      // R9 readback through the window and through banked path
      acc(1, 0, 8'h00, 1, 0, 0);
      acc(1, 0, 8'h5F, 1, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 1, 1, 0, 8'h7F, 0, 0, 0, 0, "R1");
      acc(1, 1, 8'h7F, 1, 0, 0);
      // R3 boundary in both modes
      acc(1, 0, 8'h60, 1, 1, 8'h5C);
      acc(0, 0, 8'hFF, 0, 0, 0);
      acc(0, 0, 8'h60, 1, 0, 0);
      // R4 bank 0 path and the 5Fh edge
      acc(0, 0, 8'h5F, 1, 1, 8'h77);
      acc(0, 0, 8'h00, 0, 0, 0);
      // R1 bank 0 in extended mode still reaches the hidden low region
      cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 8'h5F, 0, 0, 0, 0, "R1");
      acc(1, 1, 8'h5F, 1, 0, 0);
      // R5 indirect with window-like addresses and with select set
      cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 8'h10, 12'h120, 1, 0, 0, "R5");
      cyc(0, 0, 0, 0, 0, 0, 1, 1, 1, 8'h10, 12'hABC, 0, 0, 0, "R5");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h70, 12'h005, 0, 0, 0, "R5");
      // R8 wrap near the top of memory
      cyc(0, 0, 1, 15, 1, 8'hC0, 1, 0, 0, 8'h40, 0, 0, 0, 0, "R7");
      acc(1, 0, 8'h40, 0, 0, 0);
      acc(1, 0, 8'h5F, 1, 0, 0);
      acc(1, 0, 8'h3F, 0, 0, 0);
      // Mixed stimulus against the model
      for (int k = 0; k < 400; k++) begin
         int r = int'($urandom);
         cyc(r[0] & r[1], r[5:2], r[6] & r[7], r[11:8], r[12] & r[13], r[21:14],
             r[22], r[23], r[24] & r[25], int'($urandom) % 256, int'($urandom) % 4096,
             r[26], r[27], r[31:28] * 16 + k % 16, "");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule